// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It looks up a root entry in a context table, then follows descriptors through as many as three levels of page tables. Each table entry is read as one 32-bit word through a simple read port. A leaf entry may turn up at any level, so one walk can map a 4 GB, 16 MB, 256 KB or 4 KB region. When translation is switched off, the request is answered directly and memory is not touched.

A request carries the virtual address, the context number, the context table pointer register and the translation enable bit. The walker takes one request at a time and raises `busy` while a walk is in progress. Every request ends in exactly one single-cycle response. A `resp_done` response returns the leaf entry, its level and the physical address. A `resp_fault` response returns a fault type and the level at which the walk stopped. Caching of results and permission checks belong to other blocks.

Top module: `pgw_walker`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `mem_rd_req`, `resp_done` and `resp_fault` are all low.
- R2: If a request is accepted with `xlat_en` low, `resp_done` rises in the next cycle with `resp_paddr` = {4'h0, vaddr}, `resp_level` = 0 and `resp_pte` = 0, and no memory read is issued.
- R3: The first read of an enabled walk goes to ({ctp, 4'b0000}) + context × 4, which is the root entry in the context table.
- R4: An entry whose bits [1:0] are 01 is a descriptor. If it was read at level 0, 1 or 2, the next read goes to {entry[31:2], 6'b000000} + index × 4. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R5: An entry whose bits [1:0] are 10 is a leaf. Its page number is entry[31:8]. The walk ends with `resp_done`, `resp_pte` = entry, `resp_level` = the level it was read at, and `resp_paddr` set as follows:
  - level 3: {ppn, VA[11:0]}
  - level 2: {ppn[23:6], VA[17:0]}
  - level 1: {ppn[23:12], VA[23:0]}
  - level 0: {ppn[23:20], VA[31:0]}
- R6: An entry whose bits [1:0] are 00 ends the walk with `resp_fault`, `resp_ftype` = 1 (invalid address) and `resp_level` = the level it was read at.
- R7: A descriptor read at level 3, or an entry with bits [1:0] = 11 at any level, ends the walk with `resp_fault`, `resp_ftype` = 4 (translation error) and `resp_level` = that level.
- R8: A memory error response ends the walk with `resp_ftype` = 4 and `resp_level` = the level of the failed read (0 means the context table). If error and valid arrive together, the error takes precedence.
- R9: While `busy` is high, `req_valid` is ignored. No second walk starts and the running walk's result is unchanged.
- R10: `mem_rd_req` stays high, and `mem_rd_addr` stays stable, until a valid or error response arrives.
- R11: `resp_done` and `resp_fault` are never high together, and each is a single-cycle pulse. On a fault, `resp_pte` and `resp_paddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | CTX_W | Current context number |
| req_ctp | input | 32 | Context table pointer (physical base shifted right by 4) |
| xlat_en | input | 1 | Translation enable; when low, the physical address equals the virtual address |
| busy | output | 1 | A walk is in progress |
| mem_rd_req | output | 1 | Word read request to table memory |
| mem_rd_addr | output | 36 | Physical byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data is valid |
| mem_rd_err | input | 1 | Read ended in a memory error |
| mem_rd_data | input | 32 | Entry word read from memory |
| resp_done | output | 1 | Pulse: translation succeeded |
| resp_fault | output | 1 | Pulse: translation failed |
| resp_pte | output | 32 | Leaf entry that was found (zero on a fault) |
| resp_level | output | 2 | Level of the leaf entry, or of the level where the walk stopped |
| resp_paddr | output | 36 | Translated physical address (zero on a fault) |
| resp_ftype | output | 3 | Fault type: 1 = invalid address, 4 = translation error |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a memory response and a second request. A new request can arrive while a read is still outstanding. The bench raises `req_valid` with a different address and context in the middle of a slow walk. The walk must still produce only the reads and the result of the first request, and no extra response may appear afterwards.

The second pair is the two memory responses. Error and valid can both be asserted on the same read. The bench does this at level 2 and expects a translation fault at level 2, not the decoded entry.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int ENT_W  = 32;
  localparam int PPN_W  = 24;
  localparam int VPN_W  = 20;
  localparam int LVL_W  = 2;
  localparam int IDX_W  = 8;
  localparam int FT_W   = 3;
  localparam logic [LVL_W-1:0] LAST_LVL = 2'd3;

  typedef enum logic [1:0] {
    ET_INVALID = 2'b00,
    ET_PTD     = 2'b01,
    ET_PTE     = 2'b10,
    ET_RSVD    = 2'b11
  } ent_type_e;

  typedef enum logic [FT_W-1:0] {
    FT_NONE    = 3'd0,
    FT_INVALID = 3'd1,
    FT_XLATE   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACT_DESCEND,
    ACT_LEAF,
    ACT_INVALID,
    ACT_XLATE
  } walk_act_e;

  // Physical base of the context table: register shifted left by four.
  function automatic logic [PA_W-1:0] ctx_tbl_base(input logic [31:0] ctp);
    return {ctp, 4'b0000};
  endfunction

  // Physical base of the next table named by a descriptor.
  function automatic logic [PA_W-1:0] desc_base(input logic [ENT_W-1:2] ptp);
    return {ptp, 6'b000000};
  endfunction

  // Table index taken from the virtual page number for a page-table level.
  function automatic logic [IDX_W-1:0] lvl_index(input logic [LVL_W-1:0] lvl,
                                                 input logic [VPN_W-1:0] vpn);
    case (lvl)
      2'd1:    return vpn[19:12];
      2'd2:    return {2'b00, vpn[11:6]};
      2'd3:    return {2'b00, vpn[5:0]};
      default: return '0;
    endcase
  endfunction

  // Physical address for a leaf found at a given level.
  function automatic logic [PA_W-1:0] leaf_paddr(input logic [PPN_W-1:0] ppn,
                                                 input logic [LVL_W-1:0] lvl,
                                                 input logic [VA_W-1:0] va);
    case (lvl)
      2'd0:    return {ppn[23:20], va};
      2'd1:    return {ppn[23:12], va[23:0]};
      2'd2:    return {ppn[23:6], va[17:0]};
      default: return {ppn, va[11:0]};
    endcase
  endfunction

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VPN_W-1:0] vpn,
  input  logic [CTX_W-1:0] ctx,
  output logic [PA_W-1:0]  ent_addr
);

  localparam int WORD_SHIFT = 2;

  logic [PA_W-1:0] word_off;

  always_comb begin
    if (lvl == 2'd0) begin
      word_off = PA_W'(ctx) << WORD_SHIFT;
    end else begin
      word_off = PA_W'(lvl_index(lvl, vpn)) << WORD_SHIFT;
    end
    ent_addr = tbl_base + word_off;
  end

endmodule

// File: rtl/pgw_entry_dec.sv
module pgw_entry_dec
  import pgw_pkg::*;
(
  input  logic [ENT_W-1:0] ent,
  input  logic [LVL_W-1:0] lvl,
  output walk_act_e        act,
  output logic [PA_W-1:0]  next_base
);

  ent_type_e etype;

  always_comb begin
    etype     = ent_type_e'(ent[1:0]);
    next_base = desc_base(ent[ENT_W-1:2]);
    case (etype)
      ET_INVALID: act = ACT_INVALID;
      ET_PTD:     act = (lvl == LAST_LVL) ? ACT_XLATE : ACT_DESCEND;
      ET_PTE:     act = ACT_LEAF;
      default:    act = ACT_XLATE;
    endcase
  end

endmodule

// File: rtl/pgw_leaf_fmt.sv
module pgw_leaf_fmt
  import pgw_pkg::*;
(
  input  logic [PPN_W-1:0] ppn,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va,
  output logic [PA_W-1:0]  paddr
);

  always_comb paddr = leaf_paddr(ppn, lvl, va);

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [31:0]       req_ctp,
  input  logic              xlat_en,
  output logic              busy,
  output logic              mem_rd_req,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic              mem_rd_err,
  input  logic [ENT_W-1:0]  mem_rd_data,
  output logic              resp_done,
  output logic              resp_fault,
  output logic [ENT_W-1:0]  resp_pte,
  output logic [LVL_W-1:0]  resp_level,
  output logic [PA_W-1:0]   resp_paddr,
  output logic [FT_W-1:0]   resp_ftype
);

  typedef enum logic {S_IDLE, S_READ} walk_state_e;

  walk_state_e      state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0]  va_q;
  logic [CTX_W-1:0] ctx_q;
  logic [PA_W-1:0]  base_q;

  // Named events for the checker.
  logic acc_any, acc_walk, acc_bypass;
  logic rd_ok, rd_bus_err;

  walk_act_e       act;
  logic [PA_W-1:0] next_base;
  logic [PA_W-1:0] leaf_pa;

  assign acc_any    = req_valid && (state_q == S_IDLE);
  assign acc_walk   = acc_any && xlat_en;
  assign acc_bypass = acc_any && !xlat_en;
  assign rd_bus_err = (state_q == S_READ) && mem_rd_err;
  assign rd_ok      = (state_q == S_READ) && mem_rd_valid && !mem_rd_err;

  assign busy       = (state_q != S_IDLE);
  assign mem_rd_req = (state_q == S_READ);

  pgw_addr_gen #(.CTX_W(CTX_W)) u_addr (
    .tbl_base (base_q),
    .lvl      (lvl_q),
    .vpn      (va_q[VA_W-1:VA_W-VPN_W]),
    .ctx      (ctx_q),
    .ent_addr (mem_rd_addr)
  );

  pgw_entry_dec u_dec (
    .ent       (mem_rd_data),
    .lvl       (lvl_q),
    .act       (act),
    .next_base (next_base)
  );

  pgw_leaf_fmt u_fmt (
    .ppn   (mem_rd_data[ENT_W-1:ENT_W-PPN_W]),
    .lvl   (lvl_q),
    .va    (va_q),
    .paddr (leaf_pa)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      lvl_q      <= '0;
      va_q       <= '0;
      ctx_q      <= '0;
      base_q     <= '0;
      resp_done  <= 1'b0;
      resp_fault <= 1'b0;
      resp_pte   <= '0;
      resp_level <= '0;
      resp_paddr <= '0;
      resp_ftype <= FT_NONE;
    end else begin
      resp_done  <= 1'b0;
      resp_fault <= 1'b0;
      if (acc_bypass) begin
        resp_done  <= 1'b1;
        resp_pte   <= '0;
        resp_level <= '0;
        resp_paddr <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
        resp_ftype <= FT_NONE;
      end else if (acc_walk) begin
        state_q <= S_READ;
        lvl_q   <= '0;
        va_q    <= req_vaddr;
        ctx_q   <= req_ctx;
        base_q  <= ctx_tbl_base(req_ctp);
      end else if (rd_bus_err) begin
        state_q    <= S_IDLE;
        resp_fault <= 1'b1;
        resp_pte   <= '0;
        resp_paddr <= '0;
        resp_level <= lvl_q;
        resp_ftype <= FT_XLATE;
      end else if (rd_ok) begin
        case (act)
          ACT_DESCEND: begin
            lvl_q  <= lvl_q + 2'd1;
            base_q <= next_base;
          end
          ACT_LEAF: begin
            state_q    <= S_IDLE;
            resp_done  <= 1'b1;
            resp_pte   <= mem_rd_data;
            resp_paddr <= leaf_pa;
            resp_level <= lvl_q;
            resp_ftype <= FT_NONE;
          end
          ACT_INVALID: begin
            state_q    <= S_IDLE;
            resp_fault <= 1'b1;
            resp_pte   <= '0;
            resp_paddr <= '0;
            resp_level <= lvl_q;
            resp_ftype <= FT_INVALID;
          end
          default: begin
            state_q    <= S_IDLE;
            resp_fault <= 1'b1;
            resp_pte   <= '0;
            resp_paddr <= '0;
            resp_level <= lvl_q;
            resp_ftype <= FT_XLATE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk #(
  parameter int CTX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      req_vaddr,
  input logic [CTX_W-1:0] req_ctx,
  input logic [31:0]      req_ctp,
  input logic             busy,
  input logic             mem_rd_req,
  input logic [35:0]      mem_rd_addr,
  input logic             mem_rd_valid,
  input logic             mem_rd_err,
  input logic [31:0]      mem_rd_data,
  input logic             resp_done,
  input logic             resp_fault,
  input logic [31:0]      resp_pte,
  input logic [1:0]       resp_level,
  input logic [35:0]      resp_paddr,
  input logic [2:0]       resp_ftype,
  input logic             acc_walk,
  input logic             acc_bypass,
  input logic             rd_ok,
  input logic             rd_bus_err,
  input logic [1:0]       lvl_q
);

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_done && resp_fault));

  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bypass |=> resp_done && !busy && !mem_rd_req &&
                   resp_paddr == {4'h0, $past(req_vaddr)});

  a_r3_root_read: assert property (@(posedge clk) disable iff (!rst_n)
    acc_walk |=> mem_rd_req &&
                 mem_rd_addr == ({$past(req_ctp), 4'b0000} + (36'($past(req_ctx)) << 2)));

  a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid && !mem_rd_err) |=> mem_rd_req && $stable(mem_rd_addr));

  a_r8_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bus_err |=> resp_fault && resp_ftype == 3'd4 && resp_level == $past(lvl_q));

  a_r6_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && mem_rd_data[1:0] == 2'b00) |=> resp_fault && resp_ftype == 3'd1);

  a_r5_leaf: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && mem_rd_data[1:0] == 2'b10) |=> resp_done && resp_pte == $past(mem_rd_data));

  a_r4_descend: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && mem_rd_data[1:0] == 2'b01 && lvl_q != 2'd3) |=>
      mem_rd_req && !resp_done && !resp_fault && lvl_q == $past(lvl_q) + 2'd1);

endmodule

bind pgw_walker pgw_walker_chk #(.CTX_W(CTX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_vaddr    (req_vaddr),
  .req_ctx      (req_ctx),
  .req_ctp      (req_ctp),
  .busy         (busy),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_err   (mem_rd_err),
  .mem_rd_data  (mem_rd_data),
  .resp_done    (resp_done),
  .resp_fault   (resp_fault),
  .resp_pte     (resp_pte),
  .resp_level   (resp_level),
  .resp_paddr   (resp_paddr),
  .resp_ftype   (resp_ftype),
  .acc_walk     (acc_walk),
  .acc_bypass   (acc_bypass),
  .rd_ok        (rd_ok),
  .rd_bus_err   (rd_bus_err),
  .lvl_q        (lvl_q)
);

// File: tb/test_pgw_walker.sv
module test_pgw_walker;

  localparam logic [31:0] CTP  = 32'h0000_1000;
  localparam logic [35:0] CT   = 36'h0_0001_0000;
  localparam logic [35:0] L1B  = 36'h0_0002_0000;
  localparam logic [35:0] L2B  = 36'h0_0003_0400;
  localparam logic [35:0] L3B  = 36'h8_0004_0000;
  localparam logic [23:0] PPN  = 24'hA5C37E;
  localparam logic [31:0] LEAF = {PPN, 6'h2d, 2'b10};
  localparam logic [7:0]  CTX_OK  = 8'd2;
  localparam logic [7:0]  CTX_BAD = 8'hFF;

  logic        clk, rst_n;
  logic        req_valid, xlat_en;
  logic [31:0] req_vaddr, req_ctp;
  logic [7:0]  req_ctx;
  logic        busy, mem_rd_req;
  logic [35:0] mem_rd_addr;
  logic        mem_rd_valid, mem_rd_err;
  logic [31:0] mem_rd_data;
  logic        resp_done, resp_fault;
  logic [31:0] resp_pte;
  logic [1:0]  resp_level;
  logic [35:0] resp_paddr;
  logic [2:0]  resp_ftype;

  pgw_walker #(.CTX_W(8)) i_pgw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ctx(req_ctx), .req_ctp(req_ctp), .xlat_en(xlat_en), .busy(busy),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_err(mem_rd_err), .mem_rd_data(mem_rd_data), .resp_done(resp_done),
    .resp_fault(resp_fault), .resp_pte(resp_pte), .resp_level(resp_level),
    .resp_paddr(resp_paddr), .resp_ftype(resp_ftype)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Table memory model
  logic [31:0] mem_q [logic [35:0]];
  logic [35:0] rd_log [0:7];
  int  rd_cnt = 0;
  int  lat = 0;
  int  wait_cnt = 0;
  bit  err_en = 0;
  bit  err_both = 0;
  logic [35:0] err_addr = '0;

  always @(negedge clk) begin
    if (mem_rd_valid || mem_rd_err) begin
      mem_rd_valid = 1'b0;
      mem_rd_err   = 1'b0;
      wait_cnt     = 0;
    end else if (mem_rd_req) begin
      if (wait_cnt >= lat) begin
        if (rd_cnt < 8) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
        if (err_en && mem_rd_addr == err_addr) begin
          mem_rd_err   = 1'b1;
          mem_rd_valid = err_both;
          mem_rd_data  = 32'h0;
        end else begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem_q.exists(mem_rd_addr) ? mem_q[mem_rd_addr] : 32'h0;
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ptd(input logic [35:0] b);
    return {b[35:6], 2'b01};
  endfunction

  function automatic logic [35:0] ea(input logic [35:0] b, input int idx);
    return b + 36'(idx) * 36'd4;
  endfunction

  // Captured response
  logic        r_done, r_fault;
  logic [1:0]  r_lvl;
  logic [2:0]  r_ft;
  logic [35:0] r_pa;
  logic [31:0] r_pte;
  bit          poke_busy;

  task automatic do_walk(input logic [31:0] va, input logic [7:0] ctx, input logic en,
                         input bit poke);
    bit got = 0;
    int n = 0;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_ctx = ctx; xlat_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && n < 60) begin
      if (resp_done || resp_fault) begin
        got = 1;
        r_done = resp_done; r_fault = resp_fault; r_lvl = resp_level;
        r_ft = resp_ftype; r_pa = resp_paddr; r_pte = resp_pte;
      end else begin
        if (poke && n == 0) begin
          poke_busy = busy;
          req_valid = 1'b1; req_vaddr = va ^ 32'hFF00_0000; req_ctx = ctx + 8'd1;
          xlat_en = 1'b0;
        end else begin
          req_valid = 1'b0;
        end
        @(negedge clk);
        n++;
      end
    end
    req_valid = 1'b0;
    chk(got, "R11 response arrives", 64'(got), 64'd1);
    @(negedge clk);
    chk(!resp_done && !resp_fault, "R11 single-cycle pulse",
        {62'd0, resp_done, resp_fault}, 64'd0);
  endtask

  task automatic expect_resp(input string tag, input bit e_done, input logic [1:0] e_lvl,
                             input logic [2:0] e_ft, input logic [35:0] e_pa,
                             input logic [31:0] e_pte);
    logic [7:0] a_o, e_o;
    a_o = {r_done, r_fault, r_lvl, 1'b0, r_ft};
    e_o = {e_done, !e_done, e_lvl, 1'b0, e_ft};
    chk(a_o == e_o, {tag, " outcome/level/ftype"}, 64'(a_o), 64'(e_o));
    chk(r_pa == e_pa && r_pte == e_pte, {tag, " paddr/pte"},
        {r_pa[27:0], r_pte}, {e_pa[27:0], e_pte});
    if (r_pa[35:28] != e_pa[35:28])
      chk(1'b0, {tag, " paddr high"}, 64'(r_pa), 64'(e_pa));
  endtask

  task automatic build(input int leaf);
    mem_q.delete();
    mem_q[ea(CT, int'(CTX_OK))] = (leaf == 0) ? LEAF : ptd(L1B);
    if (leaf >= 1) mem_q[ea(L1B, 'h12)] = (leaf == 1) ? LEAF : ptd(L2B);
    if (leaf >= 2) mem_q[ea(L2B, 'h05)] = (leaf == 2) ? LEAF : ptd(L3B);
    if (leaf >= 3) mem_q[ea(L3B, 'h2a)] = LEAF;
  endtask

  localparam logic [31:0] VA_HIT = {8'h12, 6'h05, 6'h2a, 12'h9c4};

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_ctx = '0; req_ctp = CTP;
    xlat_en = 1'b0; mem_rd_valid = 1'b0; mem_rd_err = 1'b0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_rd_req && !resp_done && !resp_fault, "R1 outputs in reset",
        {60'd0, busy, mem_rd_req, resp_done, resp_fault}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd_req && !resp_done && !resp_fault, "R1 outputs after reset",
        {60'd0, busy, mem_rd_req, resp_done, resp_fault}, 64'd0);

    // R2 bypass
    do_walk(32'hDEAD_BEEF, CTX_OK, 1'b0, 0);
    expect_resp("R2 bypass", 1, 2'd0, 3'd0, 36'h0_DEAD_BEEF, 32'h0);
    chk(rd_cnt == 0, "R2 no memory read", 64'(rd_cnt), 64'd0);

    // Sweep: leaf level x context x index match pattern x offset
    for (int leaf = 0; leaf < 4; leaf++) begin
      build(leaf);
      for (int cs = 0; cs < 2; cs++) begin
        for (int m = 0; m < 8; m++) begin
          for (int off = 0; off < 2; off++) begin
            logic [31:0] va;
            logic [7:0]  cx;
            bit          ed;
            logic [1:0]  el;
            logic [2:0]  ef;
            logic [35:0] ep;
            logic [31:0] et;
            va = {m[0] ? 8'h12 : 8'h34, m[1] ? 6'h05 : 6'h11,
                  m[2] ? 6'h2a : 6'h3f, off[0] ? 12'hfff : 12'h000};
            cx = cs[0] ? CTX_BAD : CTX_OK;
            lat = (leaf + m + off) % 3;
            ed = 0; el = 2'd0; ef = 3'd1; ep = '0; et = '0;
            if (cs == 1) begin
              el = 2'd0;
            end else if (leaf == 0) begin
              ed = 1; el = 2'd0; ep = {PPN[23:20], va};
            end else if (!m[0]) begin
              el = 2'd1;
            end else if (leaf == 1) begin
              ed = 1; el = 2'd1; ep = {PPN[23:12], va[23:0]};
            end else if (!m[1]) begin
              el = 2'd2;
            end else if (leaf == 2) begin
              ed = 1; el = 2'd2; ep = {PPN[23:6], va[17:0]};
            end else if (!m[2]) begin
              el = 2'd3;
            end else begin
              ed = 1; el = 2'd3; ep = {PPN, va[11:0]};
            end
            if (ed) begin ef = 3'd0; et = LEAF; end
            do_walk(va, cx, 1'b1, 0);
            // R5 leaf formats, R6 invalid faults
            expect_resp(ed ? "R5 leaf" : "R6 invalid", ed, el, ef, ep, et);
            chk(rd_log[0] == ea(CT, int'(cx)), "R3 root entry address",
                64'(rd_log[0]), 64'(ea(CT, int'(cx))));
            if (leaf == 3 && m == 7 && cs == 0) begin
              chk(rd_cnt == 4, "R4 read count", 64'(rd_cnt), 64'd4);
              chk(rd_log[1] == ea(L1B, 'h12), "R4 level1 address",
                  64'(rd_log[1]), 64'(ea(L1B, 'h12)));
              chk(rd_log[2] == ea(L2B, 'h05), "R4 level2 address",
                  64'(rd_log[2]), 64'(ea(L2B, 'h05)));
              chk(rd_log[3] == ea(L3B, 'h2a), "R4 level3 address",
                  64'(rd_log[3]), 64'(ea(L3B, 'h2a)));
            end
          end
        end
      end
    end

    // R7 descriptor at level 3
    build(3); lat = 1;
    mem_q[ea(L3B, 'h2a)] = ptd(L1B);
    do_walk(VA_HIT, CTX_OK, 1'b1, 0);
    expect_resp("R7 descriptor at level 3", 0, 2'd3, 3'd4, '0, '0);

    // R7 reserved type at level 2 and level 0
    build(3);
    mem_q[ea(L2B, 'h05)] = 32'h1234_5673;
    do_walk(VA_HIT, CTX_OK, 1'b1, 0);
    expect_resp("R7 reserved at level 2", 0, 2'd2, 3'd4, '0, '0);
    build(3);
    mem_q[ea(CT, int'(CTX_OK))] = 32'h0000_0003;
    do_walk(VA_HIT, CTX_OK, 1'b1, 0);
    expect_resp("R7 reserved at level 0", 0, 2'd0, 3'd4, '0, '0);

    // R8 memory error at the context table
    build(3); lat = 0;
    err_en = 1; err_both = 0; err_addr = ea(CT, int'(CTX_OK));
    do_walk(VA_HIT, CTX_OK, 1'b1, 0);
    expect_resp("R8 error at level 0", 0, 2'd0, 3'd4, '0, '0);

    // R8 error together with valid at level 2
    err_both = 1; err_addr = ea(L2B, 'h05); lat = 2;
    do_walk(VA_HIT, CTX_OK, 1'b1, 0);
    expect_resp("R8 error beats valid at level 2", 0, 2'd2, 3'd4, '0, '0);
    chk(rd_cnt == 3, "R8 walk stops at failed read", 64'(rd_cnt), 64'd3);
    err_en = 0; err_both = 0;

    // R9 request while busy is ignored
    build(3); lat = 2;
    do_walk(VA_HIT, CTX_OK, 1'b1, 1);
    chk(poke_busy, "R9 walker busy when poked", 64'(poke_busy), 64'd1);
    expect_resp("R9 first walk result kept", 1, 2'd3, 3'd0, {PPN, VA_HIT[11:0]}, LEAF);
    chk(rd_cnt == 4, "R9 no reads for ignored request", 64'(rd_cnt), 64'd4);
    for (int i = 0; i < 8; i++) begin
      if (resp_done || resp_fault || busy)
        chk(1'b0, "R9 no late response", {61'd0, resp_done, resp_fault, busy}, 64'd0);
      @(negedge clk);
    end
    chk(!busy && !mem_rd_req, "R10 idle after walks", {62'd0, busy, mem_rd_req}, 64'd0);

    summary();
    $finish;
  end

endmodule